// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block chooses which of up to ten interrupt sources a small 8-bit controller core should service next, and it keeps track of nesting. Peripherals drive level request flags. For the two serial ports, the request is the OR of the receive-done and transmit-done flags. For timer 2, the request is the OR of its overflow and external flags. Software owns the enable and priority settings through a byte-wide register port and clears the flags itself. The arbiter never clears a flag.

Each source is assigned to either the low or the high level. A fixed ten-slot polling order settles ties inside a level, and two of those slots are reserved and never request. When a request is chosen, the block raises `irqReq` with the slot index on `irqIdx` and holds both until the core acknowledges. The acknowledge marks the granted level as in service. A return pulse ends the innermost routine. A low-level routine can be preempted by a high-level request. A high-level routine cannot be interrupted by anything.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, all four configuration registers read 0x00, `irqReq` is low and neither level is in service.
- R2: The register port is written on a clock edge when `regWrEn` is high, and `regRdData` shows the register at `regAddr` combinationally. The four addresses are as follows. Address 0 is the main enable register: bit 7 global enable, bit 5 timer 2, bit 4 first serial port, bit 3 timer 1, bit 2 ext int 1, bit 1 timer 0, bit 0 ext int 0, and bit 6 reads 0. Address 1 is the main priority register: same source bits, with bits 7 and 6 reading 0. Address 2 is the extension enable register: bit 4 second serial port, bit 1 I2C, and the other bits read 0. Address 3 is the extension priority register, with the same layout as address 2.
- R3: A source can be granted only when its own enable bit and the global enable bit are both 1.
- R4: A serial port requests when either its receive-done or its transmit-done flag is high. Timer 2 requests when either its overflow flag or its external flag is high.
- R5: Within one level, the earliest slot wins. The slots, in order, are: 0 ext int 0, 1 second serial port, 2 timer 0, 3 I2C, 4 ext int 1, 5 reserved, 6 timer 1, 7 reserved, 8 first serial port, 9 timer 2. `irqIdx` reports this slot number and is never 5 or 7.
- R6: A priority bit of 1 places the source at the high level. An eligible high-level request beats any low-level request, whatever their slot order.
- R7: `irqReq` rises on the first clock edge after an eligible request appears. `irqReq` and `irqIdx` then stay unchanged until `irqAck`, even if the request is withdrawn or a better one arrives.
- R8: `irqAck` while `irqReq` is high drops `irqReq` on the next edge and marks the granted level as in service. `irqAck` while `irqReq` is low has no effect.
- R9: While a low-level routine is in service, only high-level requests are granted. While a high-level routine is in service, no request is granted.
- R10: An `irqRet` pulse clears the high in-service flag if it is set, and otherwise clears the low flag. With both flags set, the low flag remains set after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| extInt0 | input | 1 | External interrupt 0 flag |
| extInt1 | input | 1 | External interrupt 1 flag |
| tmr0Flag | input | 1 | Timer 0 flag |
| tmr1Flag | input | 1 | Timer 1 flag |
| tmr2Ovf | input | 1 | Timer 2 overflow flag |
| tmr2Ext | input | 1 | Timer 2 external flag |
| ser1RxDone | input | 1 | First serial port receive-done flag |
| ser1TxDone | input | 1 | First serial port transmit-done flag |
| ser2RxDone | input | 1 | Second serial port receive-done flag |
| ser2TxDone | input | 1 | Second serial port transmit-done flag |
| i2cFlag | input | 1 | I2C flag |
| irqAck | input | 1 | Core acknowledge pulse |
| irqRet | input | 1 | Return-from-interrupt pulse |
| irqReq | output | 1 | Service request strobe |
| irqIdx | output | 4 | Slot index of the granted source |

## Verification
The ordering is exercised by raising every real source at once at the low level and then retiring them one by one. This walk must visit slots 0, 1, 2, 3, 4, 6, 8 and 9 in turn, which separates a correct encoder from a reversed one or one that skips slots. A pair made of a late high-level source and an early low-level one shows whether level outranks slot order. Nesting patterns hold a low routine open and then offer a further low request, which must wait, and a high request, which must preempt. The return pulse is then shown to unwind only the inner level. Single-flag patterns with the alternate receive, transmit or timer 2 flag confirm the OR inputs. Requests with the individual or global enable cleared, and a held grant whose source withdraws, must show no grant and no change of index, respectively.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int NUM_SLOTS = 10;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int REG_W     = 8;

  // Polling slots, earliest first; the order is the tie-break within a level.
  localparam int SLOT_EXT0 = 0;
  localparam int SLOT_SER2 = 1;
  localparam int SLOT_TMR0 = 2;
  localparam int SLOT_I2C  = 3;
  localparam int SLOT_EXT1 = 4;
  localparam int SLOT_TMR1 = 6;
  localparam int SLOT_SER1 = 8;
  localparam int SLOT_TMR2 = 9;

  localparam logic [NUM_SLOTS-1:0] RSVD_MASK = NUM_SLOTS'((1 << 5) | (1 << 7));

  localparam logic [1:0] ADDR_MAIN_EN  = 2'd0;
  localparam logic [1:0] ADDR_MAIN_PRI = 2'd1;
  localparam logic [1:0] ADDR_EXT_EN   = 2'd2;
  localparam logic [1:0] ADDR_EXT_PRI  = 2'd3;

  localparam logic [REG_W-1:0] MAIN_EN_MASK  = 8'hBF;
  localparam logic [REG_W-1:0] MAIN_PRI_MASK = 8'h3F;
  localparam logic [REG_W-1:0] EXT_MASK      = 8'h12;

  typedef struct packed {
    logic loadGrant;  // capture the current winner into the grant register
    logic busyHi;     // high level in service
    logic busyLo;     // low level in service
  } ctrlToDp_t;

endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  parameter int IW    = IDX_W,
  parameter int RW    = REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [RW-1:0]    regWrData,
  output logic [RW-1:0]    regRdData,
  input  logic [SLOTS-1:0] rawSlots,
  input  ctrlToDp_t        ctl,
  output logic             winValid,
  output logic [IW-1:0]    grantIdx,
  output logic             grantHi
);

  logic [RW-1:0]    mainEnQ, mainPriQ, extEnQ, extPriQ;
  logic [SLOTS-1:0] slotEn, slotPri, pend, hiCand, loCand;
  logic [IW-1:0]    winIdx;
  logic             winHi;

  function automatic logic [IW-1:0] firstSet(input logic [SLOTS-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainEnQ  <= '0;
      mainPriQ <= '0;
      extEnQ   <= '0;
      extPriQ  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_MAIN_EN:  mainEnQ  <= regWrData & MAIN_EN_MASK;
        ADDR_MAIN_PRI: mainPriQ <= regWrData & MAIN_PRI_MASK;
        ADDR_EXT_EN:   extEnQ   <= regWrData & EXT_MASK;
        default:       extPriQ  <= regWrData & EXT_MASK;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_MAIN_EN:  regRdData = mainEnQ;
      ADDR_MAIN_PRI: regRdData = mainPriQ;
      ADDR_EXT_EN:   regRdData = extEnQ;
      default:       regRdData = extPriQ;
    endcase
  end

  // Spread register bits onto the polling slots.
  always_comb begin
    slotEn  = '0;
    slotPri = '0;
    slotEn[SLOT_EXT0] = mainEnQ[0];  slotPri[SLOT_EXT0] = mainPriQ[0];
    slotEn[SLOT_TMR0] = mainEnQ[1];  slotPri[SLOT_TMR0] = mainPriQ[1];
    slotEn[SLOT_EXT1] = mainEnQ[2];  slotPri[SLOT_EXT1] = mainPriQ[2];
    slotEn[SLOT_TMR1] = mainEnQ[3];  slotPri[SLOT_TMR1] = mainPriQ[3];
    slotEn[SLOT_SER1] = mainEnQ[4];  slotPri[SLOT_SER1] = mainPriQ[4];
    slotEn[SLOT_TMR2] = mainEnQ[5];  slotPri[SLOT_TMR2] = mainPriQ[5];
    slotEn[SLOT_SER2] = extEnQ[4];   slotPri[SLOT_SER2] = extPriQ[4];
    slotEn[SLOT_I2C]  = extEnQ[1];   slotPri[SLOT_I2C]  = extPriQ[1];
  end

  assign pend   = rawSlots & slotEn & ~RSVD_MASK & {SLOTS{mainEnQ[7]}};
  assign hiCand = pend & slotPri;
  assign loCand = pend & ~slotPri;

  always_comb begin
    winValid = 1'b0;
    winHi    = 1'b0;
    winIdx   = '0;
    if (!ctl.busyHi && |hiCand) begin
      winValid = 1'b1;
      winHi    = 1'b1;
      winIdx   = firstSet(hiCand);
    end else if (!ctl.busyHi && !ctl.busyLo && |loCand) begin
      winValid = 1'b1;
      winIdx   = firstSet(loCand);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantIdx <= '0;
      grantHi  <= 1'b0;
    end else if (ctl.loadGrant) begin
      grantIdx <= winIdx;
      grantHi  <= winHi;
    end
  end

  AST_GRANT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadGrant |-> mainEnQ[7]); // R3
  AST_GRANT_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadGrant |=> !RSVD_MASK[grantIdx]); // R5
  AST_GRANT_SOURCE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadGrant |=> slotEn[grantIdx]); // R3
  AST_HIGH_OUTRANKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadGrant && (|hiCand) |=> grantHi); // R6

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      winValid,
  input  logic      grantHi,
  input  logic      irqAck,
  input  logic      irqRet,
  output logic      irqReq,
  output ctrlToDp_t ctl
);

  logic reqQ, busyHiQ, busyLoQ;
  logic busyHiD, busyLoD;
  logic ackTake, loadGrant;

  assign loadGrant = !reqQ && winValid;
  assign ackTake   = reqQ && irqAck;

  always_comb begin
    busyHiD = busyHiQ;
    busyLoD = busyLoQ;
    if (irqRet) begin
      if (busyHiQ) busyHiD = 1'b0;
      else         busyLoD = 1'b0;
    end
    if (ackTake) begin
      if (grantHi) busyHiD = 1'b1;
      else         busyLoD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      busyHiQ <= 1'b0;
      busyLoQ <= 1'b0;
    end else begin
      busyHiQ <= busyHiD;
      busyLoQ <= busyLoD;
      if (loadGrant)    reqQ <= 1'b1;
      else if (ackTake) reqQ <= 1'b0;
    end
  end

  assign irqReq        = reqQ;
  assign ctl.loadGrant = loadGrant;
  assign ctl.busyHi    = busyHiQ;
  assign ctl.busyLo    = busyLoQ;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && !irqAck |=> reqQ); // R7
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && irqAck |=> !reqQ); // R8
  AST_ACK_MARKS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && irqAck && grantHi |=> busyHiQ); // R8
  AST_ACK_MARKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && irqAck && !grantHi |=> busyLoQ); // R8
  AST_HIGH_NEVER_PREEMPTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) |-> !$past(busyHiQ)); // R9
  AST_LOW_WAITS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) && !grantHi |-> !$past(busyLoQ)); // R9
  AST_RET_UNWINDS_INNER: assert property (@(posedge clk) disable iff (!rstN)
    irqRet && busyHiQ && !(reqQ && irqAck) |=> !busyHiQ && (busyLoQ == $past(busyLoQ))); // R10

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             extInt0,
  input  logic             extInt1,
  input  logic             tmr0Flag,
  input  logic             tmr1Flag,
  input  logic             tmr2Ovf,
  input  logic             tmr2Ext,
  input  logic             ser1RxDone,
  input  logic             ser1TxDone,
  input  logic             ser2RxDone,
  input  logic             ser2TxDone,
  input  logic             i2cFlag,
  input  logic             irqAck,
  input  logic             irqRet,
  output logic             irqReq,
  output logic [IDX_W-1:0] irqIdx
);

  logic [NUM_SLOTS-1:0] rawSlots;
  ctrlToDp_t            ctl;
  logic                 winValid, grantHi;

  always_comb begin
    rawSlots            = '0;
    rawSlots[SLOT_EXT0] = extInt0;
    rawSlots[SLOT_SER2] = ser2RxDone | ser2TxDone;
    rawSlots[SLOT_TMR0] = tmr0Flag;
    rawSlots[SLOT_I2C]  = i2cFlag;
    rawSlots[SLOT_EXT1] = extInt1;
    rawSlots[SLOT_TMR1] = tmr1Flag;
    rawSlots[SLOT_SER1] = ser1RxDone | ser1TxDone;
    rawSlots[SLOT_TMR2] = tmr2Ovf | tmr2Ext;
  end

  irq_nest_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rawSlots  (rawSlots),
    .ctl       (ctl),
    .winValid  (winValid),
    .grantIdx  (irqIdx),
    .grantHi   (grantHi)
  );

  irq_nest_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .grantHi  (grantHi),
    .irqAck   (irqAck),
    .irqRet   (irqRet),
    .irqReq   (irqReq),
    .ctl      (ctl)
  );

  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !irqAck |=> $stable(irqIdx)); // R7

endmodule

// File: tb/tb_irq_nest_arb.sv
module tb_irq_nest_arb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic extInt0, extInt1, tmr0Flag, tmr1Flag, tmr2Ovf, tmr2Ext;
  logic ser1RxDone, ser1TxDone, ser2RxDone, ser2TxDone, i2cFlag;
  logic irqAck, irqRet, irqReq;
  logic [3:0] irqIdx;

  int    nChecks = 0;
  int    nFail   = 0;
  bit    holdAck = 1'b0;
  bit    done    = 1'b0;
  int    expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_nest_arb dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .extInt0(extInt0), .extInt1(extInt1), .tmr0Flag(tmr0Flag), .tmr1Flag(tmr1Flag),
    .tmr2Ovf(tmr2Ovf), .tmr2Ext(tmr2Ext), .ser1RxDone(ser1RxDone), .ser1TxDone(ser1TxDone),
    .ser2RxDone(ser2RxDone), .ser2TxDone(ser2TxDone), .i2cFlag(i2cFlag),
    .irqAck(irqAck), .irqRet(irqRet), .irqReq(irqReq), .irqIdx(irqIdx)
  );

  task automatic check(string tag, bit ok, int act, int exp, string what);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  // Monitor: pops the expected slot for every grant and acknowledges it.
  initial begin
    irqAck = 1'b0;
    forever begin
      @(negedge clk);
      if (!holdAck && rstN === 1'b1 && irqReq === 1'b1) begin
        if (expQ.size() == 0) begin
          check("R7", 1'b0, int'(irqIdx), -1, "unexpected grant");
        end else begin
          int    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, int'(irqIdx) == e, int'(irqIdx), e, "granted slot");
        end
        irqAck = 1'b1;
        @(negedge clk);
        irqAck = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("R7", 1'b0, 0, 1, "watchdog expired");
      finishRun();
    end
  end

  task automatic expectGrant(int idx, string tag);
    expQ.push_back(idx);
    tagQ.push_back(tag);
  endtask

  task automatic waitDrain(string tag);
    int guard = 0;
    while (expQ.size() != 0 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    check(tag, expQ.size() == 0, expQ.size(), 0, "pending expected grants");
    repeat (2) @(negedge clk);
  endtask

  task automatic checkNoReq(int n, string tag);
    bit seen = 1'b0;
    holdAck = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irqReq !== 1'b0) seen = 1'b1;
    end
    check(tag, !seen, int'(seen), 0, "request seen while blocked");
    holdAck = 1'b0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdData === exp, int'(regRdData), int'(exp), $sformatf("read addr %0d", a));
  endtask

  task automatic pulseRet();
    @(negedge clk);
    irqRet = 1'b1;
    @(negedge clk);
    irqRet = 1'b0;
  endtask

  // Drive the request for a slot: slot 1 via receive, slot 8 via transmit, slot 9 via external flag.
  task automatic setSlot(int idx, logic v);
    case (idx)
      0: extInt0 = v;
      1: ser2RxDone = v;
      2: tmr0Flag = v;
      3: i2cFlag = v;
      4: extInt1 = v;
      6: tmr1Flag = v;
      8: ser1TxDone = v;
      9: tmr2Ext = v;
      default: ;
    endcase
  endtask

  initial begin
    int order[8] = '{0, 1, 2, 3, 4, 6, 8, 9};
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; irqRet = 1'b0;
    {extInt0, extInt1, tmr0Flag, tmr1Flag, tmr2Ovf, tmr2Ext} = '0;
    {ser1RxDone, ser1TxDone, ser2RxDone, ser2TxDone, i2cFlag} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) rdCheck(2'(a), 8'h00, "R1");
    check("R1", irqReq === 1'b0, int'(irqReq), 0, "irqReq after reset");

    // R2: writable bits per register
    wrReg(2'd0, 8'hFF); rdCheck(2'd0, 8'hBF, "R2");
    wrReg(2'd1, 8'hFF); rdCheck(2'd1, 8'h3F, "R2");
    wrReg(2'd2, 8'hFF); rdCheck(2'd2, 8'h12, "R2");
    wrReg(2'd3, 8'hFF); rdCheck(2'd3, 8'h12, "R2");
    for (int a = 0; a < 4; a++) wrReg(2'(a), 8'h00);

    // R3: individual and global enables
    extInt0 = 1'b1; tmr0Flag = 1'b1;
    checkNoReq(8, "R3");
    wrReg(2'd0, 8'h03);
    checkNoReq(8, "R3");
    expectGrant(0, "R3");
    wrReg(2'd0, 8'h83);
    waitDrain("R3");
    extInt0 = 1'b0;
    expectGrant(2, "R3");
    pulseRet();
    waitDrain("R3");
    tmr0Flag = 1'b0;
    pulseRet();

    // R5: full low-level walk through the polling order
    wrReg(2'd0, 8'hBF); wrReg(2'd2, 8'h12);
    expectGrant(0, "R5");
    for (int i = 0; i < 8; i++) setSlot(order[i], 1'b1);
    waitDrain("R5");
    for (int i = 1; i < 8; i++) begin
      setSlot(order[i-1], 1'b0);
      expectGrant(order[i], "R5");
      pulseRet();
      waitDrain("R5");
    end
    setSlot(9, 1'b0);
    pulseRet();

    // R4: the alternate flag of each ORed source
    expectGrant(8, "R4"); ser1RxDone = 1'b1; waitDrain("R4"); ser1RxDone = 1'b0; pulseRet();
    expectGrant(9, "R4"); tmr2Ovf = 1'b1;    waitDrain("R4"); tmr2Ovf = 1'b0;    pulseRet();
    expectGrant(1, "R4"); ser2TxDone = 1'b1; waitDrain("R4"); ser2TxDone = 1'b0; pulseRet();

    // R6: late high-level slot beats early low-level slot
    wrReg(2'd1, 8'h20);
    expectGrant(9, "R6");
    extInt0 = 1'b1; tmr2Ovf = 1'b1;
    waitDrain("R6");
    checkNoReq(6, "R9");
    tmr2Ovf = 1'b0;
    expectGrant(0, "R10");
    pulseRet();
    waitDrain("R10");

    // R9: low in service; low waits, high preempts
    tmr1Flag = 1'b1;
    checkNoReq(6, "R9");
    expectGrant(9, "R9");
    tmr2Ovf = 1'b1;
    waitDrain("R9");
    checkNoReq(6, "R9");
    tmr2Ovf = 1'b0;
    pulseRet();
    checkNoReq(6, "R10");
    extInt0 = 1'b0;
    expectGrant(6, "R10");
    pulseRet();
    waitDrain("R10");
    tmr1Flag = 1'b0;
    pulseRet();
    wrReg(2'd1, 8'h00);

    // R7: request and index held until acknowledge
    holdAck = 1'b1;
    @(negedge clk);
    tmr0Flag = 1'b1;
    @(negedge clk);
    check("R7", irqReq === 1'b1, int'(irqReq), 1, "irqReq one edge after request");
    check("R7", irqIdx === 4'd2, int'(irqIdx), 2, "held index");
    tmr0Flag = 1'b0;
    extInt0 = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", irqReq === 1'b1, int'(irqReq), 1, "irqReq held after withdraw");
    check("R7", irqIdx === 4'd2, int'(irqIdx), 2, "index held after better request");
    expectGrant(2, "R7");
    holdAck = 1'b0;
    waitDrain("R7");
    extInt0 = 1'b0;
    pulseRet();

    // R8: stray acknowledge ignored; real acknowledge marks low level
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    expectGrant(6, "R8");
    tmr1Flag = 1'b1;
    waitDrain("R8");
    extInt1 = 1'b1;
    checkNoReq(5, "R8");
    extInt1 = 1'b0; tmr1Flag = 1'b0;
    pulseRet();
    repeat (3) @(negedge clk);

    done = 1'b1;
    finishRun();
  end

endmodule